// File: doc/BRIEF.md
# Gated Hit Scaler with Terminal Count

This block counts hits, the rising edges of one of two asynchronous front-panel lines. Both lines pass through a synchronizer and an edge detector, and a select bit in the configuration register picks which line feeds the counter. A hit is counted only while the synchronous enable input `gate_i` is high. A synchronous clear input `clr_i` returns the count to zero.

The counter runs towards a programmable terminal value. When the count reaches that value, the block raises `end_pulse_o` for one clock. After that, the count either holds at the terminal value or wraps to zero on the next counted hit, as the auto-restart bit selects. A small register port reads and writes the configuration, and reads back the 16-bit count and a status word that carries the end-count pulse. Any write to the configuration restarts the count.

Control is a three-state machine:

| State | Meaning |
|-------|---------|
| `ST_ARM` | Entered from reset, clear or a configuration write. It lasts one cycle and compares the zero count with the limit. Hits that arrive in this cycle are not counted. |
| `ST_RUN` | The count is below the limit and counted hits increment it. |
| `ST_END` | The count equals the limit. |

The state transitions are:

- **ARM→END**: taken when the limit is 0, and pulses.
- **ARM→RUN**: taken when the limit is not 0.
- **RUN→RUN**: a counted hit that leaves the count below the limit.
- **RUN→END**: a counted hit that makes the count equal the limit, and pulses.
- **END→RUN**: a counted hit with auto-restart on and a non-zero limit. It sets the count to 0.
- **END→END**: taken when auto-restart is off, which holds the count. It is also taken on a counted hit with auto-restart on and a limit of 0, which keeps the count at 0 and pulses again.
- **any→ARM**: taken on a clear or a configuration write.

Top module: `hit_scaler`

## Requirements
- R1: After reset the count reads 0, `end_pulse_o` is low, status bit 0 is 0, and the configuration register (address 0) reads 0x03FF: limit 1023, auto-restart off, source line A.
- R2: Each rising edge of the selected line that is counted while the gate is high adds exactly one to the count, which is read at address 1.
- R3: A line held high for many cycles counts as one hit.
- R4: While `gate_i` is low, hits leave the count unchanged.
- R5: Configuration bit 11 selects the source: 0 selects `src_a_i` and 1 selects `src_b_i`. Edges on the line that is not selected are not counted.
- R6: `clr_i` high at a clock edge sets the count to 0 at that edge.
- R7: With auto-restart off (configuration bit 10 = 0), the count stops at the limit (configuration bits 9:0), and further hits leave it there until a clear or a configuration write.
- R8: `end_pulse_o` goes high for exactly one cycle, in the same cycle the count first shows the limit value.
- R9: With auto-restart on, the first counted hit after the limit sets the count to 0, and counting continues from there.
- R10: With a limit of 0, the end count is reached one cycle after a clear or configuration write, with no hit.
- R11: Status register bit 0 (address 2) reads the current level of the end-count pulse.
- R12: Writes to the count or status addresses change neither the count nor the configuration.
- R13: A write to the configuration register sets the count to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a_i | input | 1 | Hit line A, asynchronous |
| src_b_i | input | 1 | Hit line B, asynchronous |
| gate_i | input | 1 | Count enable, synchronous |
| clr_i | input | 1 | Count clear, synchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | COUNT_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | COUNT_W | Register read data, combinational |
| end_pulse_o | output | 1 | One-cycle end-count pulse |

## Verification
The bench builds the block with its default parameters: a 16-bit count, a 10-bit limit, two synchronizer stages and a reset limit of 1023. With these values the 12-bit configuration field positions and the reset readback are the ones the requirements state. Because the bench programs limits of 0 and 3 through the register port, stopping, wrapping and the immediate end count are each reached within a few hits. The two-stage synchronizer fixes the hit-to-count latency at three edges, and the bench's hit task allows for that.

// File: rtl/scaler_pkg.sv
`timescale 1ns/1ps
package scaler_pkg;

    typedef enum logic [1:0] {
        ST_ARM = 2'd0,
        ST_RUN = 2'd1,
        ST_END = 2'd2
    } scl_state_e;

    localparam int SCL_ADDR_CFG    = 0;
    localparam int SCL_ADDR_COUNT  = 1;
    localparam int SCL_ADDR_STATUS = 2;

endpackage

// File: rtl/scl_edge_sync.sv
`timescale 1ns/1ps
module scl_edge_sync #(
    parameter int N_LINES = 2,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] lines_i,
    output logic [N_LINES-1:0] rise_o
);

    localparam int TOP = STAGES - 1;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], lines_i[g]};
                prev_q  <= chain_q[TOP];
            end
        end

        assign rise_o[g] = chain_q[TOP] & ~prev_q;

        AST_EDGE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]); // R3
    end

endmodule

// File: rtl/scl_counter_fsm.sv
`timescale 1ns/1ps
module scl_counter_fsm
    import scaler_pkg::*;
#(
    parameter int COUNT_W = 16,
    parameter int LIMIT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_i,
    input  logic               gate_i,
    input  logic               clr_i,
    input  logic               restart_i,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               auto_i,
    output logic [COUNT_W-1:0] count_o,
    output logic               end_pulse_o
);

    localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

    scl_state_e         state_q, state_d;
    logic [COUNT_W-1:0] count_q, count_d;
    logic               pulse_q, pulse_d;
    logic [COUNT_W-1:0] limit_ext;
    logic [COUNT_W-1:0] count_inc;
    logic               take_hit;
    logic               limit_zero;

    assign limit_ext  = COUNT_W'(limit_i);
    assign count_inc  = count_q + ONE;
    assign take_hit   = hit_i & gate_i;
    assign limit_zero = (limit_i == '0);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        pulse_d = 1'b0;
        if (clr_i || restart_i) begin
            state_d = ST_ARM;
            count_d = '0;
        end else begin
            unique case (state_q)
                ST_ARM: begin
                    if (limit_zero) begin
                        state_d = ST_END;
                        pulse_d = 1'b1;
                    end else begin
                        state_d = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (take_hit) begin
                        count_d = count_inc;
                        if (count_inc == limit_ext) begin
                            state_d = ST_END;
                            pulse_d = 1'b1;
                        end
                    end
                end
                ST_END: begin
                    if (take_hit && auto_i) begin
                        count_d = '0;
                        if (limit_zero) begin
                            pulse_d = 1'b1;
                        end else begin
                            state_d = ST_RUN;
                        end
                    end
                end
                default: begin
                    state_d = ST_ARM;
                    count_d = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
        end else begin
            state_q <= state_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            count_q <= count_d;
            pulse_q <= pulse_d;
        end
    end

    assign count_o     = count_q;
    assign end_pulse_o = pulse_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (count_q == '0 && !pulse_q)); // R6

    AST_GATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_i && !clr_i && !restart_i) |=> $stable(count_q)); // R4

    AST_NO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !restart_i) |=> (count_q == $past(count_q) ||
                                    count_q == $past(count_q) + ONE ||
                                    count_q == '0)); // R2

    AST_HOLD_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_END && !auto_i && !clr_i && !restart_i) |=> $stable(count_q)); // R7

    AST_RUN_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (count_q < limit_ext)); // R7

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q); // R8

    AST_PULSE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (count_q == limit_ext)); // R8

endmodule

// File: rtl/scl_regs.sv
`timescale 1ns/1ps
module scl_regs
    import scaler_pkg::*;
#(
    parameter int ADDR_W    = 2,
    parameter int DATA_W    = 16,
    parameter int LIMIT_W   = 10,
    parameter int LIMIT_RST = 1023
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [DATA_W-1:0]  count_i,
    input  logic               end_pulse_i,
    output logic [LIMIT_W-1:0] limit_o,
    output logic               auto_o,
    output logic               src_sel_o,
    output logic               restart_o
);

    localparam int CFG_W   = LIMIT_W + 2;
    localparam int BIT_AUT = LIMIT_W;
    localparam int BIT_SRC = LIMIT_W + 1;
    localparam logic [CFG_W-1:0] CFG_RST = CFG_W'(LIMIT_RST);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(SCL_ADDR_CFG);
    localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(SCL_ADDR_COUNT);
    localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(SCL_ADDR_STATUS);

    logic [CFG_W-1:0] cfg_q;
    logic             cfg_hit;
    logic             unused_wr_bits;

    assign cfg_hit        = wr_en_i && (wr_addr_i == A_CFG);
    assign unused_wr_bits = ^wr_data_i[DATA_W-1:CFG_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RST;
        end else if (cfg_hit) begin
            cfg_q <= wr_data_i[CFG_W-1:0];
        end
    end

    assign limit_o   = cfg_q[LIMIT_W-1:0];
    assign auto_o    = cfg_q[BIT_AUT];
    assign src_sel_o = cfg_q[BIT_SRC];
    assign restart_o = cfg_hit;

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            A_CFG:   rd_data_o = DATA_W'(cfg_q);
            A_CNT:   rd_data_o = count_i;
            A_STA:   rd_data_o = DATA_W'(end_pulse_i);
            default: rd_data_o = '0;
        endcase
    end

    AST_RO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i != A_CFG) |=> $stable(cfg_q)); // R12

endmodule

// File: rtl/hit_scaler.sv
`timescale 1ns/1ps
module hit_scaler #(
    parameter int COUNT_W     = 16,
    parameter int LIMIT_W     = 10,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2,
    parameter int LIMIT_RST   = 1023
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               src_a_i,
    input  logic               src_b_i,
    input  logic               gate_i,
    input  logic               clr_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [COUNT_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [COUNT_W-1:0] rd_data_o,
    output logic               end_pulse_o
);

    localparam int N_LINES = 2;

    logic [N_LINES-1:0] lines;
    logic [N_LINES-1:0] rises;
    logic               hit;
    logic [LIMIT_W-1:0] limit;
    logic               auto_rst;
    logic               src_sel;
    logic               restart;
    logic [COUNT_W-1:0] count;
    logic               pulse;

    assign lines = {src_b_i, src_a_i};
    assign hit   = rises[src_sel];

    scl_edge_sync #(
        .N_LINES (N_LINES),
        .STAGES  (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i (lines),
        .rise_o  (rises)
    );

    scl_counter_fsm #(
        .COUNT_W (COUNT_W),
        .LIMIT_W (LIMIT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit),
        .gate_i      (gate_i),
        .clr_i       (clr_i),
        .restart_i   (restart),
        .limit_i     (limit),
        .auto_i      (auto_rst),
        .count_o     (count),
        .end_pulse_o (pulse)
    );

    scl_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (COUNT_W),
        .LIMIT_W   (LIMIT_W),
        .LIMIT_RST (LIMIT_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en_i),
        .wr_addr_i   (wr_addr_i),
        .wr_data_i   (wr_data_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .count_i     (count),
        .end_pulse_i (pulse),
        .limit_o     (limit),
        .auto_o      (auto_rst),
        .src_sel_o   (src_sel),
        .restart_o   (restart)
    );

    assign end_pulse_o = pulse;

    AST_CFG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == ADDR_W'(0)) |=> (count == '0 && !pulse)); // R13

endmodule

// File: tb/test_hit_scaler.sv
`timescale 1ns/1ps
module test_hit_scaler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_a = 1'b0;
    logic        src_b = 1'b0;
    logic        gate = 1'b1;
    logic        clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [1:0]  rd_addr = 2'd1;
    logic [15:0] rd_data;
    logic        end_pulse;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    hit_scaler i_hit_scaler (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_a_i     (src_a),
        .src_b_i     (src_b),
        .gate_i      (gate),
        .clr_i       (clr),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .end_pulse_o (end_pulse)
    );

    always @(negedge clk) if (rst_n && end_pulse) pulses = pulses + 1;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cfg(input int lim, input bit aut, input bit src);
        return {4'd0, src, aut, 10'(lim)};
    endfunction

    task automatic hit(input int line, input int hold);
        @(negedge clk);
        if (line == 0) src_a = 1'b1; else src_b = 1'b1;
        repeat (hold) @(negedge clk);
        src_a = 1'b0; src_b = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        int v;
        repeat (2) @(negedge clk);
        rd(2'd1, v); chk("R1 count", v, 0);
        chk("R1 pulse", int'(end_pulse), 0);
        rd(2'd0, v); chk("R1 config", v, 16'h03FF);
        rd(2'd2, v); chk("R1 status", v, 0);
    endtask

    task automatic t_count();
        int v;
        for (int i = 0; i < 5; i++) hit(0, 4);
        rd(2'd1, v); chk("R2 five hits", v, 5);
    endtask

    task automatic t_level();
        int v;
        hit(0, 30);
        rd(2'd1, v); chk("R3 long level", v, 6);
    endtask

    task automatic t_gate();
        int v;
        @(negedge clk); gate = 1'b0;
        for (int i = 0; i < 3; i++) hit(0, 4);
        rd(2'd1, v); chk("R4 gate low", v, 6);
        @(negedge clk); gate = 1'b1;
    endtask

    task automatic t_clear();
        int v;
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        rd(2'd1, v); chk("R6 clear", v, 0);
    endtask

    task automatic t_restart();
        int v;
        hit(0, 4); hit(0, 4);
        rd(2'd1, v); chk("R2 before restart", v, 2);
        wr(2'd0, cfg(1023, 1'b0, 1'b1));
        rd(2'd1, v); chk("R13 cfg write zeroes", v, 0);
    endtask

    task automatic t_source();
        int v;
        hit(0, 4); hit(0, 4);
        rd(2'd1, v); chk("R5 line A ignored", v, 0);
        for (int i = 0; i < 3; i++) hit(1, 4);
        rd(2'd1, v); chk("R5 line B counted", v, 3);
    endtask

    task automatic t_stop();
        int v, p0;
        wr(2'd0, cfg(3, 1'b0, 1'b0));
        p0 = pulses;
        for (int i = 0; i < 5; i++) hit(0, 4);
        rd(2'd1, v); chk("R7 hold at limit", v, 3);
        chk("R8 one pulse", pulses - p0, 1);
    endtask

    task automatic t_auto();
        int v, p0;
        wr(2'd0, cfg(3, 1'b1, 1'b0));
        p0 = pulses;
        for (int i = 0; i < 4; i++) hit(0, 4);
        rd(2'd1, v); chk("R9 wrap to zero", v, 0);
        chk("R8 pulse at limit", pulses - p0, 1);
        for (int i = 0; i < 3; i++) hit(0, 4);
        rd(2'd1, v); chk("R9 second lap", v, 3);
        chk("R8 second pulse", pulses - p0, 2);
    endtask

    task automatic t_ro();
        int v;
        wr(2'd1, 16'hBEEF);
        wr(2'd2, 16'h1234);
        rd(2'd1, v); chk("R12 count kept", v, 3);
        rd(2'd0, v); chk("R12 config kept", v, 16'h0403);
    endtask

    task automatic t_zero();
        int v, p0;
        p0 = pulses;
        rd_addr = 2'd2;
        wr(2'd0, cfg(0, 1'b0, 1'b0));
        rd(2'd2, v); chk("R10 arm cycle quiet", v, 0);
        @(negedge clk);
        rd(2'd2, v); chk("R11 status shows pulse", v, 1);
        chk("R10 pulse without hit", int'(end_pulse), 1);
        @(negedge clk);
        rd(2'd2, v); chk("R8 pulse dropped", v, 0);
        hit(0, 4); hit(0, 4);
        rd(2'd1, v); chk("R7 hold at zero", v, 0);
        chk("R10 single pulse", pulses - p0, 1);
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_level();
        t_gate();
        t_clear();
        t_restart();
        t_source();
        t_stop();
        t_auto();
        t_ro();
        t_zero();
        summary();
        $finish;
    end

endmodule